// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives a 16-pin shared address/data bus towards external memory on behalf of one internal requester. A request carries an address, write data, a direction bit and a width bit. The port runs the bus through up to three phases: an address-latch phase, in which a latch strobe makes an external latch capture part of the address; in byte mode, a low-address phase; and a data phase with an active-low read or write strobe. A read returns its data on a one-cycle completion pulse.

The latch phase is only spent when it is needed. The port keeps a copy of the field it last had latched, which is the upper sixteen address bits in byte mode and the lower sixteen in word mode. An access whose field and width match that copy skips the latch phase. A flag input takes the pins away from the port. While it is high, the strobes are parked inactive, the pad drivers are released, any access in progress is dropped and the latched-address record is forgotten.

Top module: `mux_bus_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `ad_out` is 0, `ad_oe` is 1, `rd_n` and `wr_n` are 1, `alat` is 0 and `rsp_done` is 0.
- R2: In word mode (`req_wide`=1), the latch phase drives address bits 15..0 on `ad_out` and is followed directly by the data phase, with no low-address phase.
- R3: In byte mode (`req_wide`=0), the latch phase drives address bits 23..8. A low-address phase follows that has address bits 7..0 on `ad_out[7:0]` and zero above. In the data phase, write data moves on bits 7..0 only and read data is returned zero-extended.
- R4: The latch phase is skipped only when the field for the current width equals the last latched field and the width is also unchanged. Any difference in that field, or a change of width, brings the latch phase back.
- R5: The first access after reset, and the first access after the flag input falls, always includes the latch phase.
- R6: In a read data phase, `rd_n` is 0 and `ad_oe` is 0. `ad_in` is sampled on the final cycle of the strobe. `rsp_done` rises in the next cycle with that value on `rsp_rdata`.
- R7: In a write data phase, `wr_n` is 0, `ad_oe` is 1 and the write data is on `ad_out`.
- R8: Every phase lasts `phase_len` cycles; a value of 0 is treated as 1.
- R9: With `ale_low`=0 the latch strobe is active high. With `ale_low`=1 it is active low. When no latch phase is running, `alat` holds the inactive level for the current polarity.
- R10: While `flag_mode` is 1, `req_ready` is 0. From the next cycle on, `rd_n`, `wr_n` and `alat` are inactive and `ad_oe` is 0. An access already in progress is dropped without a `rsp_done` pulse.
- R11: A request is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while no access is running. `rsp_done` is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Port idle and able to take a request |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data (byte mode uses bits 7..0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = word mode, 0 = byte mode |
| phase_len | input | 4 | Cycles per phase (0 acts as 1) |
| ale_low | input | 1 | 1 = latch strobe active low |
| flag_mode | input | 1 | Hand the pins to flag use |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| ad_out | output | 16 | Address/data pad output value |
| ad_oe | output | 1 | Pad output enable |
| ad_in | input | 16 | Pad input value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| alat | output | 1 | Address latch strobe |

## Verification
The flag input can arrive in the same cycle as an active phase, and the latch-skip decision can coincide with a change of width or with leaving flag mode. The bench raises the flag in the middle of a long read strobe. It expects no completion pulse, parked pins from the next cycle on, and a latch phase on the next access to the same address. Separately, it repeats one address across a switch between word and byte mode and expects the latch phase to return even where the numeric field might match.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_ALO   = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;
endpackage

// File: rtl/mbp_addr_tracker.sv
// Holds the field last presented to the external latch and reports whether
// the current access must latch again.
module mbp_addr_tracker #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               update,
  input  logic [FIELD_W-1:0] field,
  input  logic               wide,
  output logic               need_latch
);
  logic               vld_q;
  logic               wide_q;
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vld_q   <= 1'b0;
      wide_q  <= 1'b0;
      field_q <= '0;
    end else if (update) begin
      vld_q   <= 1'b1;
      wide_q  <= wide;
      field_q <= field;
    end
  end

  always_comb begin
    need_latch = !vld_q || (wide != wide_q) || (field != field_q);
  end
endmodule

// File: rtl/mbp_phase_timer.sv
// Down-counter giving each bus phase its programmed length.
module mbp_phase_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    eff_len = (len == '0) ? LEN_W'(1) : len;
    last    = (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= eff_len - LEN_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/mbp_pin_encoder.sv
// Maps the upcoming phase onto pad values; registered by the top module.
module mbp_pin_encoder
  import mbp_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  phase_e          phase,
  input  logic            flag_mode,
  input  logic            ale_low,
  input  logic            write,
  input  logic            wide,
  input  logic [AD_W-1:0] latch_field,
  input  logic [AD_W-1:0] low_addr,
  input  logic [AD_W-1:0] wdata,
  output logic [AD_W-1:0] ad_d,
  output logic            oe_d,
  output logic            rd_n_d,
  output logic            wr_n_d,
  output logic            alat_d
);
  localparam int BYTE_W = AD_W / 2;

  always_comb begin
    ad_d   = '0;
    oe_d   = !flag_mode;
    rd_n_d = 1'b1;
    wr_n_d = 1'b1;
    alat_d = ale_low;
    unique case (phase)
      PH_LATCH: begin
        ad_d   = latch_field;
        alat_d = !ale_low;
      end
      PH_ALO: begin
        ad_d = {{(AD_W-BYTE_W){1'b0}}, low_addr[BYTE_W-1:0]};
      end
      PH_DATA: begin
        if (write) begin
          wr_n_d = 1'b0;
          ad_d   = wide ? wdata : {{(AD_W-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
        end else begin
          rd_n_d = 1'b0;
          oe_d   = 1'b0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
  import mbp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AD_W   = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [LEN_W-1:0]  phase_len,
  input  logic              ale_low,
  input  logic              flag_mode,
  output logic              rsp_done,
  output logic [AD_W-1:0]   rsp_rdata,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              alat
);
  localparam int BYTE_W = AD_W / 2;
  localparam int HI_LSB = ADDR_W - AD_W;

  phase_e            st_q, st_d;
  logic              accept;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [AD_W-1:0]   wdata_q, cur_wdata;
  logic              write_q, cur_write;
  logic              wide_q, cur_wide;
  logic [AD_W-1:0]   field_c;
  logic              need_latch;
  logic              t_load, t_last;
  logic              finish;
  logic [AD_W-1:0]   ad_d;
  logic              oe_d, rd_n_d, wr_n_d, alat_d;

  always_comb begin
    req_ready = (st_q == PH_IDLE) && !flag_mode && !rst;
    accept    = req_valid && req_ready;
    cur_addr  = accept ? req_addr  : addr_q;
    cur_wdata = accept ? req_wdata : wdata_q;
    cur_write = accept ? req_write : write_q;
    cur_wide  = accept ? req_wide  : wide_q;
    field_c   = cur_wide ? cur_addr[AD_W-1:0] : cur_addr[ADDR_W-1:HI_LSB];
  end

  mbp_addr_tracker #(.FIELD_W(AD_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clear      (flag_mode),
    .update     (accept && need_latch),
    .field      (field_c),
    .wide       (cur_wide),
    .need_latch (need_latch)
  );

  mbp_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .len  (phase_len),
    .last (t_last)
  );

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    finish = 1'b0;
    if (flag_mode) begin
      st_d = PH_IDLE;
    end else begin
      unique case (st_q)
        PH_IDLE: if (accept) begin
          t_load = 1'b1;
          if (need_latch)    st_d = PH_LATCH;
          else if (req_wide) st_d = PH_DATA;
          else               st_d = PH_ALO;
        end
        PH_LATCH: if (t_last) begin
          t_load = 1'b1;
          st_d   = wide_q ? PH_DATA : PH_ALO;
        end
        PH_ALO: if (t_last) begin
          t_load = 1'b1;
          st_d   = PH_DATA;
        end
        PH_DATA: if (t_last) begin
          finish = 1'b1;
          st_d   = PH_IDLE;
        end
        default: st_d = PH_IDLE;
      endcase
    end
  end

  mbp_pin_encoder #(.AD_W(AD_W)) u_enc (
    .phase       (st_d),
    .flag_mode   (flag_mode),
    .ale_low     (ale_low),
    .write       (cur_write),
    .wide        (cur_wide),
    .latch_field (field_c),
    .low_addr    (cur_addr[AD_W-1:0]),
    .wdata       (cur_wdata),
    .ad_d        (ad_d),
    .oe_d        (oe_d),
    .rd_n_d      (rd_n_d),
    .wr_n_d      (wr_n_d),
    .alat_d      (alat_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
        wide_q  <= req_wide;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out    <= '0;
      ad_oe     <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      alat      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      ad_out   <= ad_d;
      ad_oe    <= oe_d;
      rd_n     <= rd_n_d;
      wr_n     <= wr_n_d;
      alat     <= alat_d;
      rsp_done <= finish;
      if (finish && !write_q) begin
        rsp_rdata <= wide_q ? ad_in : {{(AD_W-BYTE_W){1'b0}}, ad_in[BYTE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/mux_bus_port_chk.sv
module mux_bus_port_chk #(
  parameter int AD_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ale_low,
  input logic            flag_mode,
  input logic            req_ready,
  input logic            rsp_done,
  input logic            rd_n,
  input logic            wr_n,
  input logic            alat,
  input logic            ad_oe,
  input logic [AD_W-1:0] ad_out
);
  AST_RESET_PINS: assert property (@(posedge clk)
    $past(rst) |-> (ad_out == '0 && ad_oe && rd_n && wr_n && !alat && !rsp_done)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R6
  AST_FLAG_PARK: assert property (@(posedge clk) disable iff (rst)
    flag_mode |=> (rd_n && wr_n && !ad_oe && alat == $past(ale_low))); // R10
  AST_FLAG_NO_READY: assert property (@(posedge clk) disable iff (rst)
    flag_mode |-> !req_ready); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R11
  AST_READY_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (rd_n && wr_n)); // R11
endmodule

bind mux_bus_port mux_bus_port_chk #(.AD_W(AD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale_low   (ale_low),
  .flag_mode (flag_mode),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .alat      (alat),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out)
);

// File: tb/tb_mux_bus_port.sv
`timescale 1ns/1ps
module tb_mux_bus_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b1;
  logic [3:0]  phase_len = 4'd2;
  logic        ale_low = 1'b0;
  logic        flag_mode = 1'b0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in;
  logic        rd_n, wr_n, alat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] mem    [256];
  logic [15:0] shadow [256];
  logic [15:0] latch_q = '0;
  logic [7:0]  lo_q = '0;
  logic [7:0]  idx;

  always #4 clk = ~clk;

  assign idx   = req_wide ? latch_q[7:0] : lo_q;
  assign ad_in = !rd_n ? mem[idx] : 16'hA5A5;

  mux_bus_port dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_wide(req_wide), .phase_len(phase_len), .ale_low(ale_low),
    .flag_mode(flag_mode), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .rd_n(rd_n),
    .wr_n(wr_n), .alat(alat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ad_out in reset", 32'(ad_out), 0);
    check("R1 oe in reset", 32'(ad_oe), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ad_out after reset", 32'(ad_out), 0);
    check("R1 strobes after reset", {30'd0, rd_n, wr_n}, 32'h3);
    check("R1 alat after reset", 32'(alat), 0);
    check("R1 done after reset", 32'(rsp_done), 0);
  endtask

  // One access, monitored cycle by cycle; checks phases, lengths and data.
  task automatic do_access(input bit w, input bit wd, input logic [23:0] a,
                           input logic [15:0] d, input bit exp_ale, input string tag);
    int n, t, nale, nlo, nrd, nwr, oe_bad;
    logic [15:0] got, exp_rd, fld;
    n = (phase_len == 0) ? 1 : int'(phase_len);
    nale = 0; nlo = 0; nrd = 0; nwr = 0; oe_bad = 0; t = 0;
    @(negedge clk);
    req_addr = a; req_wdata = d; req_write = w; req_wide = wd; req_valid = 1'b1;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_done && t < 200) begin
      if (alat ^ ale_low) begin
        nale++; latch_q = ad_out;
      end else if (!rd_n) begin
        nrd++; if (ad_oe) oe_bad++;
      end else if (!wr_n) begin
        nwr++; mem[idx] = ad_out;
        if (!ad_oe) oe_bad++;
      end else begin
        nlo++; lo_q = ad_out[7:0];
        if (ad_out[15:8] != 8'h00) oe_bad++;
      end
      @(negedge clk);
      t++;
    end
    got = rsp_rdata;
    check("R11 done seen", 32'(rsp_done), 1);
    fld = wd ? a[15:0] : a[23:8];
    check({tag, " latch cycles"}, nale, exp_ale ? n : 0);
    if (exp_ale) check(wd ? "R2 latched field" : "R3 latched field", 32'(latch_q), 32'(fld));
    check("R3 low-address cycles", nlo, wd ? 0 : n);
    if (!wd) check("R3 low byte", 32'(lo_q), 32'(a[7:0]));
    if (w) begin
      check("R7 write strobe cycles", nwr, n);
      check("R7 oe during write", oe_bad, 0);
      shadow[a[7:0]] = wd ? d : {8'h00, d[7:0]};
      check("R7 stored data", 32'(mem[a[7:0]]), 32'(shadow[a[7:0]]));
    end else begin
      exp_rd = wd ? shadow[a[7:0]] : {8'h00, shadow[a[7:0]][7:0]};
      check("R8 read strobe cycles", nrd, n);
      check("R6 oe during read", oe_bad, 0);
      check("R6 read data", 32'(got), 32'(exp_rd));
    end
    @(negedge clk);
    check("R11 done one cycle", 32'(rsp_done), 0);
  endtask

  task automatic test_polarity();
    ale_low = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 idle level active-low", 32'(alat), 1);
    do_access(1'b0, 1'b1, 24'h004477, 16'h0, 1'b1, "R9");
    check("R9 idle after access", 32'(alat), 1);
    ale_low = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 idle level active-high", 32'(alat), 0);
  endtask

  task automatic test_flag();
    flag_mode = 1'b1;
    req_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 ready in flag mode", 32'(req_ready), 0);
    check("R10 strobes parked", {29'd0, rd_n, wr_n, alat}, 32'h6);
    check("R10 pads released", 32'(ad_oe), 0);
    req_valid = 1'b0;
    flag_mode = 1'b0;
    @(negedge clk);
    do_access(1'b0, 1'b1, 24'h004477, 16'h0, 1'b1, "R5 after flag");
  endtask

  task automatic test_abort();
    int seen;
    seen = 0;
    phase_len = 4'd8;
    @(negedge clk);
    req_addr = 24'h009901; req_write = 1'b0; req_wide = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (rsp_done) seen++;
      if (!rd_n) flag_mode = 1'b1;
    end
    check("R10 no done after abort", seen, 0);
    check("R10 strobes after abort", {30'd0, rd_n, wr_n}, 32'h3);
    flag_mode = 1'b0;
    phase_len = 4'd2;
    @(negedge clk);
    do_access(1'b0, 1'b1, 24'h009901, 16'h0, 1'b1, "R5 after abort");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101 ^ 16'h3C00);
      shadow[i] = 16'(i * 16'h0101 ^ 16'h3C00);
    end
    do_reset();
    phase_len = 4'd2;
    do_access(1'b1, 1'b1, 24'h001234, 16'hBEEF, 1'b1, "R5 first");
    do_access(1'b0, 1'b1, 24'h001234, 16'h0, 1'b0, "R4 repeat");
    do_access(1'b0, 1'b1, 24'h001235, 16'h0, 1'b1, "R4 changed");
    do_access(1'b1, 1'b0, 24'h00AB12, 16'h775A, 1'b1, "R4 width change");
    do_access(1'b0, 1'b0, 24'h00AB34, 16'h0, 1'b0, "R4 byte repeat");
    do_access(1'b0, 1'b0, 24'h00AB12, 16'h0, 1'b0, "R4 byte repeat2");
    do_access(1'b0, 1'b0, 24'h00AC12, 16'h0, 1'b1, "R4 byte upper change");
    phase_len = 4'd0;
    do_access(1'b0, 1'b1, 24'h00AC12, 16'h0, 1'b1, "R8 len0");
    phase_len = 4'd3;
    do_access(1'b1, 1'b1, 24'h00AC12, 16'h1357, 1'b0, "R8 len3");
    phase_len = 4'd2;
    test_polarity();
    test_flag();
    test_abort();
    do_reset();
    do_access(1'b0, 1'b1, 24'h009901, 16'h0, 1'b1, "R5 after reset");
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule